// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block takes a ten-byte slice of instruction memory, aligned so that its lowest byte is the byte at the current program counter, and breaks the leading instruction into named parts. The parts are the operation code, the function code, two register identifiers and a 64-bit constant. It also reports how many bytes the instruction occupies, the address of the instruction that follows, whether the encoding is legal, and whether it is a halt. All of the decode logic is combinational. A bank of registers, loaded under a capture enable, holds the results for the next pipeline stage.

The first byte alone sets the length. Its upper nibble is the operation code and its lower nibble is the function code. Byte 1, when the instruction has one, carries two register identifiers. The constant is eight bytes in little-endian order. Register identifier 0xF means "no register". Every field that an instruction does not use leaves the block as zero, or as 0xF for register fields. Downstream logic can therefore use the outputs without checking the operation code first.

Top module: `vl_inst_decoder`

## Requirements
- R1: Operation codes 0x0, 0x1 and 0x9 give a length of 1. Codes 0x2, 0x6, 0xA and 0xB give 2. Codes 0x7 and 0x8 give 9. Codes 0x3, 0x4 and 0x5 give 10. Bytes 1 to 9 never change the length.
- R2: An illegal encoding sets `bad_q` to 1 and `stat_q` to 4. It also forces `len_q` and `valc_q` to 0, `ra_q` and `rb_q` to 0xF, `halt_q` to 0 and `valpc_q` to `pc_in`. `icode_q` and `ifun_q` still show the raw nibbles.
- R3: Codes 0x2 and 0x7 accept function codes 0 to 6, and code 0x6 accepts 0 to 3. Every other known code accepts only function code 0. Operation codes 0xC to 0xF are always illegal.
- R4: For codes 0x2, 0x4, 0x5, 0x6, 0xA and 0xB, `ra_q` is bits 7:4 of byte 1. For codes 0x2, 0x3, 0x4, 0x5 and 0x6, `rb_q` is bits 3:0 of byte 1. The values are passed through without any check.
- R5: A register field that the instruction does not use reads 0xF, whatever byte 1 holds. This covers `ra_q` for code 0x3 and `rb_q` for codes 0xA and 0xB.
- R6: For codes 0x7 and 0x8, `valc_q` is bytes 1 to 8, with byte 1 as the least significant byte. For codes 0x3, 0x4 and 0x5, it is bytes 2 to 9, with byte 2 as the least significant byte. For all other codes it is 0.
- R7: `valpc_q` equals `pc_in` plus the decoded length, modulo 2^64.
- R8: The single legal byte 0x00 sets `halt_q` to 1 and `stat_q` to 2. Every other legal encoding gives `stat_q` = 1 and `halt_q` = 0.
- R9: Outputs change only on a rising clock edge while `cap_en` is 1. They take effect from the edge that samples `cap_en`. While `cap_en` is 0 they hold.
- R10: After reset, `len_q` and `valc_q` are 0, `valpc_q` is 0, `ra_q` and `rb_q` are 0xF, `stat_q` is 1, `bad_q` and `halt_q` are 0, and `icode_q` and `ifun_q` are 0. Reset is released through a two-stage synchronizer, so captures are ignored until two edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Load the decoded result into the output registers |
| pc_in | input | 64 | Address of byte 0 of the window |
| win_in | input | 80 | Instruction window, byte k at bits 8k+7:8k |
| icode_q | output | 4 | Operation code nibble |
| ifun_q | output | 4 | Function code nibble |
| ra_q | output | 4 | First register identifier, 0xF if unused |
| rb_q | output | 4 | Second register identifier, 0xF if unused |
| valc_q | output | 64 | Constant or target address, 0 if unused |
| len_q | output | 4 | Instruction length in bytes, 0 if illegal |
| valpc_q | output | 64 | Address of the next instruction |
| stat_q | output | 3 | 1 normal, 2 halt, 4 illegal instruction |
| bad_q | output | 1 | Illegal encoding |
| halt_q | output | 1 | Halt instruction |

## Verification
The assertions assume that `pc_in` and `win_in` are stable around every edge on which `cap_en` is 1. They also assume the reset synchronizer has released before any decode is expected. The register-field and length properties are assumed to hold for every possible first byte, because no first byte is excluded. The stimulus changes inputs only on falling edges and waits out the synchronizer before capturing anything. It sweeps all 256 values of byte 0 under several derived byte patterns and program counters, including values close to the 64-bit wrap point.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int BYTE_W    = 8;
  localparam int NIB_W     = 4;
  localparam int WIN_BYTES = 10;
  localparam int WIN_W     = WIN_BYTES * BYTE_W;
  localparam int IMM_BYTES = 8;
  localparam int IMM_W     = IMM_BYTES * BYTE_W;
  localparam int LEN_W     = 4;
  localparam int STAT_W    = 3;
  localparam int IMM_SITES = 2;

  localparam logic [NIB_W-1:0] OP_HALT  = 4'h0;
  localparam logic [NIB_W-1:0] OP_NOP   = 4'h1;
  localparam logic [NIB_W-1:0] OP_CMOV  = 4'h2;
  localparam logic [NIB_W-1:0] OP_IRMOV = 4'h3;
  localparam logic [NIB_W-1:0] OP_RMMOV = 4'h4;
  localparam logic [NIB_W-1:0] OP_MRMOV = 4'h5;
  localparam logic [NIB_W-1:0] OP_ALU   = 4'h6;
  localparam logic [NIB_W-1:0] OP_JUMP  = 4'h7;
  localparam logic [NIB_W-1:0] OP_CALL  = 4'h8;
  localparam logic [NIB_W-1:0] OP_RET   = 4'h9;
  localparam logic [NIB_W-1:0] OP_PUSH  = 4'hA;
  localparam logic [NIB_W-1:0] OP_POP   = 4'hB;

  localparam logic [NIB_W-1:0] FN_COND_MAX = 4'd6;
  localparam logic [NIB_W-1:0] FN_ALU_MAX  = 4'd3;
  localparam logic [NIB_W-1:0] REG_NONE    = 4'hF;

  localparam logic [LEN_W-1:0] LEN_SHORT = 4'd1;
  localparam logic [LEN_W-1:0] LEN_REGS  = 4'd2;
  localparam logic [LEN_W-1:0] LEN_ADDR  = 4'd9;
  localparam logic [LEN_W-1:0] LEN_FULL  = 4'd10;

  localparam logic [STAT_W-1:0] ST_RUN  = 3'd1;
  localparam logic [STAT_W-1:0] ST_STOP = 3'd2;
  localparam logic [STAT_W-1:0] ST_ILL  = 3'd4;

  typedef struct packed {
    logic [NIB_W-1:0]  icode;
    logic [NIB_W-1:0]  ifun;
    logic [NIB_W-1:0]  ra;
    logic [NIB_W-1:0]  rb;
    logic [IMM_W-1:0]  valc;
    logic [LEN_W-1:0]  len;
    logic [STAT_W-1:0] stat;
    logic              bad;
    logic              halt;
  } dec_word_t;
endpackage

// File: rtl/ivd_class.sv
module ivd_class
  import ivd_pkg::*;
(
  input  logic [BYTE_W-1:0] head_byte,
  output logic [LEN_W-1:0]  len,
  output logic              bad,
  output logic              halt,
  output logic              ra_used,
  output logic              rb_used,
  output logic              imm_at1,
  output logic              imm_at2
);
  logic [NIB_W-1:0] op;
  logic [NIB_W-1:0] fn;
  logic             op_known;
  logic             fn_ok;
  logic [LEN_W-1:0] raw_len;
  logic             raw_ra, raw_rb, raw_i1, raw_i2;

  assign op = head_byte[BYTE_W-1:NIB_W];
  assign fn = head_byte[NIB_W-1:0];

  always_comb begin
    op_known = 1'b1;
    fn_ok    = (fn == '0);
    raw_len  = '0;
    raw_ra   = 1'b0;
    raw_rb   = 1'b0;
    raw_i1   = 1'b0;
    raw_i2   = 1'b0;
    case (op)
      OP_HALT, OP_NOP, OP_RET: raw_len = LEN_SHORT;
      OP_CMOV: begin
        raw_len = LEN_REGS; raw_ra = 1'b1; raw_rb = 1'b1;
        fn_ok   = (fn <= FN_COND_MAX);
      end
      OP_ALU: begin
        raw_len = LEN_REGS; raw_ra = 1'b1; raw_rb = 1'b1;
        fn_ok   = (fn <= FN_ALU_MAX);
      end
      OP_PUSH, OP_POP: begin
        raw_len = LEN_REGS; raw_ra = 1'b1;
      end
      OP_IRMOV: begin
        raw_len = LEN_FULL; raw_rb = 1'b1; raw_i2 = 1'b1;
      end
      OP_RMMOV, OP_MRMOV: begin
        raw_len = LEN_FULL; raw_ra = 1'b1; raw_rb = 1'b1; raw_i2 = 1'b1;
      end
      OP_JUMP: begin
        raw_len = LEN_ADDR; raw_i1 = 1'b1;
        fn_ok   = (fn <= FN_COND_MAX);
      end
      OP_CALL: begin
        raw_len = LEN_ADDR; raw_i1 = 1'b1;
      end
      default: op_known = 1'b0;
    endcase
  end

  always_comb begin
    bad     = !(op_known && fn_ok);
    halt    = !bad && (op == OP_HALT);
    len     = bad ? '0 : raw_len;
    ra_used = !bad && raw_ra;
    rb_used = !bad && raw_rb;
    imm_at1 = !bad && raw_i1;
    imm_at2 = !bad && raw_i2;
  end
endmodule

// File: rtl/ivd_fields.sv
module ivd_fields
  import ivd_pkg::*;
(
  input  logic [WIN_W-1:0] window,
  input  logic             ra_used,
  input  logic             rb_used,
  input  logic             imm_at1,
  input  logic             imm_at2,
  output logic [NIB_W-1:0] ra,
  output logic [NIB_W-1:0] rb,
  output logic [IMM_W-1:0] valc
);
  logic [IMM_W-1:0] cand [IMM_SITES];
  logic [BYTE_W-1:0] reg_byte;

  // Constant candidates start at byte 1 and byte 2; byte k sits at bits 8k+7:8k.
  for (genvar s = 0; s < IMM_SITES; s++) begin : g_site
    for (genvar k = 0; k < IMM_BYTES; k++) begin : g_byte
      assign cand[s][k*BYTE_W +: BYTE_W] = window[(k+s+1)*BYTE_W +: BYTE_W];
    end
  end

  assign reg_byte = window[BYTE_W +: BYTE_W];

  always_comb begin
    ra   = ra_used ? reg_byte[BYTE_W-1:NIB_W] : REG_NONE;
    rb   = rb_used ? reg_byte[NIB_W-1:0]      : REG_NONE;
    valc = '0;
    if (imm_at1)      valc = cand[0];
    else if (imm_at2) valc = cand[1];
  end
endmodule

// File: rtl/ivd_stage.sv
module ivd_stage
  import ivd_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  dec_word_t         d_word,
  input  logic [ADDR_W-1:0] d_next,
  output dec_word_t         q_word,
  output logic [ADDR_W-1:0] q_next
);
  dec_word_t         n_word;
  logic [ADDR_W-1:0] n_next;

  always_comb begin
    n_word = q_word;
    n_next = q_next;
    if (load) begin
      n_word = d_word;
      n_next = d_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_word.icode <= '0;
      q_word.ifun  <= '0;
      q_word.ra    <= REG_NONE;
      q_word.rb    <= REG_NONE;
      q_word.valc  <= '0;
      q_word.len   <= '0;
      q_word.stat  <= ST_RUN;
      q_word.bad   <= 1'b0;
      q_word.halt  <= 1'b0;
      q_next       <= '0;
    end else begin
      q_word <= n_word;
      q_next <= n_next;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(q_word) && $stable(q_next)));
endmodule

// File: rtl/vl_inst_decoder.sv
module vl_inst_decoder
  import ivd_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [WIN_W-1:0]  win_in,
  output logic [3:0]        icode_q,
  output logic [3:0]        ifun_q,
  output logic [3:0]        ra_q,
  output logic [3:0]        rb_q,
  output logic [IMM_W-1:0]  valc_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [ADDR_W-1:0] valpc_q,
  output logic [STAT_W-1:0] stat_q,
  output logic              bad_q,
  output logic              halt_q
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [LEN_W-1:0]  c_len;
  logic              c_bad, c_halt, c_ra, c_rb, c_i1, c_i2;
  logic [NIB_W-1:0]  f_ra, f_rb;
  logic [IMM_W-1:0]  f_valc;
  dec_word_t         d_word, q_word;
  logic [ADDR_W-1:0] d_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ivd_class u_class (
    .head_byte (win_in[BYTE_W-1:0]),
    .len       (c_len),
    .bad       (c_bad),
    .halt      (c_halt),
    .ra_used   (c_ra),
    .rb_used   (c_rb),
    .imm_at1   (c_i1),
    .imm_at2   (c_i2)
  );

  ivd_fields u_fields (
    .window  (win_in),
    .ra_used (c_ra),
    .rb_used (c_rb),
    .imm_at1 (c_i1),
    .imm_at2 (c_i2),
    .ra      (f_ra),
    .rb      (f_rb),
    .valc    (f_valc)
  );

  always_comb begin
    d_word.icode = win_in[BYTE_W-1:NIB_W];
    d_word.ifun  = win_in[NIB_W-1:0];
    d_word.ra    = f_ra;
    d_word.rb    = f_rb;
    d_word.valc  = f_valc;
    d_word.len   = c_len;
    d_word.bad   = c_bad;
    d_word.halt  = c_halt;
    if (c_bad)       d_word.stat = ST_ILL;
    else if (c_halt) d_word.stat = ST_STOP;
    else             d_word.stat = ST_RUN;
    d_next = pc_in + ADDR_W'(c_len);
  end

  ivd_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (cap_en),
    .d_word (d_word),
    .d_next (d_next),
    .q_word (q_word),
    .q_next (valpc_q)
  );

  assign icode_q = q_word.icode;
  assign ifun_q  = q_word.ifun;
  assign ra_q    = q_word.ra;
  assign rb_q    = q_word.rb;
  assign valc_q  = q_word.valc;
  assign len_q   = q_word.len;
  assign stat_q  = q_word.stat;
  assign bad_q   = q_word.bad;
  assign halt_q  = q_word.halt;

  p_len_legal_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (len_q != '0) |-> (len_q == LEN_SHORT || len_q == LEN_REGS ||
                       len_q == LEN_ADDR  || len_q == LEN_FULL));

  p_bad_clears_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bad_q |-> (len_q == '0 && valc_q == '0 && ra_q == REG_NONE &&
               rb_q == REG_NONE && stat_q == ST_ILL && !halt_q));

  p_pushpop_rb_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bad_q && (icode_q == OP_PUSH || icode_q == OP_POP)) |-> (rb_q == REG_NONE));

  p_next_addr_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_en |=> (valpc_q == $past(pc_in) + ADDR_W'(len_q)));

  p_halt_stat_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halt_q |-> (stat_q == ST_STOP && !bad_q && len_q == LEN_SHORT));
endmodule

// File: tb/sim_vl_inst_decoder.sv
module sim_vl_inst_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_en = 1'b0;
  logic [63:0] pc_in = '0;
  logic [79:0] win_in = '0;
  logic [3:0]  icode_q, ifun_q, ra_q, rb_q;
  logic [63:0] valc_q, valpc_q;
  logic [3:0]  len_q;
  logic [2:0]  stat_q;
  logic        bad_q, halt_q;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vl_inst_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pc_in(pc_in), .win_in(win_in),
    .icode_q(icode_q), .ifun_q(ifun_q), .ra_q(ra_q), .rb_q(rb_q),
    .valc_q(valc_q), .len_q(len_q), .valpc_q(valpc_q), .stat_q(stat_q),
    .bad_q(bad_q), .halt_q(halt_q)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (win=%h pc=%h)", tag, act, exp, win_in, pc_in);
    end
  endtask

  function automatic int ref_len(input logic [7:0] b0);
    logic [3:0] op, fn;
    op = b0[7:4]; fn = b0[3:0];
    if (op == 4'h2 || op == 4'h7) return (fn <= 4'd6) ? ((op == 4'h2) ? 2 : 9) : 0;
    if (op == 4'h6) return (fn <= 4'd3) ? 2 : 0;
    if (fn != 4'd0) return 0;
    if (op == 4'h0 || op == 4'h1 || op == 4'h9) return 1;
    if (op == 4'hA || op == 4'hB) return 2;
    if (op == 4'h8) return 9;
    if (op >= 4'h3 && op <= 4'h5) return 10;
    return 0;
  endfunction

  task automatic decode_one(input logic [7:0] b0, input int pat, input logic [63:0] pc);
    logic [7:0]  bytes [10];
    logic [3:0]  op;
    int          len;
    logic [63:0] exp_c;
    logic [3:0]  exp_ra, exp_rb;
    bit          ill;
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      bytes[k] = (k == 0) ? b0 : 8'(b0 * 37 + k * 91 + pat * 53);
      win_in[k*8 +: 8] = bytes[k];
    end
    pc_in  = pc;
    cap_en = 1'b1;
    @(negedge clk);
    cap_en = 1'b0;
    op  = b0[7:4];
    len = ref_len(b0);
    ill = (len == 0);
    exp_c = '0;
    if (!ill && (op == 4'h7 || op == 4'h8))
      for (int k = 0; k < 8; k++) exp_c = exp_c | (64'(bytes[k+1]) << (8*k));
    if (!ill && op >= 4'h3 && op <= 4'h5)
      for (int k = 0; k < 8; k++) exp_c = exp_c | (64'(bytes[k+2]) << (8*k));
    exp_ra = 4'hF; exp_rb = 4'hF;
    if (!ill && (op == 4'h2 || op == 4'h4 || op == 4'h5 || op == 4'h6 || op == 4'hA || op == 4'hB))
      exp_ra = bytes[1][7:4];
    if (!ill && op >= 4'h2 && op <= 4'h6)
      exp_rb = bytes[1][3:0];
    chk("R1 length", 64'(len_q), 64'(len));
    chk("R3 legality", 64'(bad_q), 64'(ill));
    chk("R2 raw nibbles", 64'({icode_q, ifun_q}), 64'(b0));
    chk("R4 R5 register A", 64'(ra_q), 64'(exp_ra));
    chk("R4 R5 register B", 64'(rb_q), 64'(exp_rb));
    chk("R6 constant", valc_q, exp_c);
    chk("R7 next address", valpc_q, pc + 64'(len));
    chk("R8 halt flag", 64'(halt_q), 64'(b0 == 8'h00));
    chk("R2 R8 status", 64'(stat_q), ill ? 64'd4 : (b0 == 8'h00) ? 64'd2 : 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values, checked both in reset and after release
    chk("R10 len", 64'(len_q), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 len", 64'(len_q), 64'd0);
    chk("R10 regs", 64'({ra_q, rb_q}), 64'hFF);
    chk("R10 const", valc_q, 64'd0);
    chk("R10 next", valpc_q, 64'd0);
    chk("R10 status", 64'(stat_q), 64'd1);
    chk("R10 flags", 64'({bad_q, halt_q, icode_q, ifun_q}), 64'd0);

    for (int pat = 0; pat < 3; pat++) begin
      for (int b = 0; b < 256; b++) begin
        logic [63:0] pc;
        pc = (pat == 0) ? 64'h0000_0000_0000_1000 :
             (pat == 1) ? 64'hFFFF_FFFF_FFFF_FFFB : 64'h7FFF_FFFF_FFFF_FFFF;
        decode_one(8'(b), pat, pc + 64'(b));
      end
    end

    // R9: with cap_en low, new inputs must not reach the outputs
    decode_one(8'h30, 5, 64'h40);
    @(negedge clk);
    win_in = {80{1'b1}};
    pc_in  = 64'h1234;
    repeat (2) @(negedge clk);
    chk("R9 hold len", 64'(len_q), 64'd10);
    chk("R9 hold next", valpc_q, 64'h4A);
    chk("R9 hold status", 64'(stat_q), 64'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule